// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter with a parallel preset and an asynchronous clear. It has two count enables. One is a plain count gate. The other also qualifies the terminal-count output, so several stages can be chained into one wider counter with look-ahead carry. Every state bit changes on the rising clock edge. The only exception is the clear, which forces the count to zero at once and does not wait for the clock.

The top module is a chain of `N_STAGES` identical stages of `STAGE_W` bits each. The global count gate goes to every stage. The cascade enable goes to stage 0 only. Each later stage takes the terminal-count output of the stage below it as its cascade enable. Seen from the ports, the chain is one counter of `STAGE_W*N_STAGES` bits. With one stage it is the basic counter. The default build is two 4-bit stages.

Top module: `casc_cnt_chain`

## Requirements
- R1: While `clr_n` is low, `q` is zero at once, without waiting for a clock edge, whatever the levels on the clock, `load_n` and both enables.
- R2: On a rising edge with `clr_n` high and `load_n` low, `q` takes the value of `din`, whatever the levels of `cnt_en` and `casc_en`.
- R3: On a rising edge with `clr_n` high, `load_n` high and both `cnt_en` and `casc_en` high, `q` increases by exactly one.
- R4: On a rising edge with `clr_n` high, `load_n` high and either enable low, `q` keeps its value.
- R5: An enabled count from the all-ones value gives zero.
- R6: `tc` is high exactly when `q` is all ones and `casc_en` is high. It follows `casc_en` within the same cycle, with no register in between, and `cnt_en` has no effect on it.
- R7: With several stages, a stage moves on only when every stage below it is all ones. The concatenated `q` therefore counts as one binary counter of the full width, and carries cross stage boundaries (for example 0x0F becomes 0x10 on 8 bits).
- R8: After an edge that loads all ones, `tc` is high during the following cycle whenever `casc_en` is high.
- R9: The clear has priority over the load, and the load has priority over counting. A low `clr_n` across an edge with `load_n` low still leaves `q` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel preset strobe, active low |
| din | input | STAGE_W*N_STAGES | Preset value |
| cnt_en | input | 1 | Count gate, does not affect `tc` |
| casc_en | input | 1 | Cascade enable, gates counting and `tc` |
| q | output | STAGE_W*N_STAGES | Count value |
| tc | output | 1 | Terminal count, for enabling the next stage or chain |

## Verification
A wrong next-state value shows up on `q` right after the rising edge that stores it. A broken carry between stages shows up only when the lower stage passes all ones. For that reason the stimulus loads values near stage boundaries very often. A fault in the terminal-count gating is visible on `tc` within the same cycle that `casc_en` or `q` changes. The bench checks `tc` both before and after each edge. A late clear shows up in the low phase right after `clr_n` falls, before any clock edge arrives.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_STEP = 2'd1,
      OP_LOAD = 2'd2
   } cnt_op_e;

   // Load beats counting; counting needs both enables.
   function automatic cnt_op_e pick_op(input logic load_n,
                                       input logic en_p,
                                       input logic en_t);
      if (!load_n)
         return OP_LOAD;
      else if (en_p && en_t)
         return OP_STEP;
      else
         return OP_HOLD;
   endfunction

endpackage

// File: rtl/cnt_next.sv
module cnt_next #(
   parameter int W = 4
) (
   input  logic           load_n,
   input  logic           en_p,
   input  logic           en_t,
   input  logic [W-1:0]   d,
   input  logic [W-1:0]   cur,
   output logic [W-1:0]   nxt
);
   import cnt_pkg::*;

   cnt_op_e op;

   always_comb begin
      op = pick_op(load_n, en_p, en_t);
      unique case (op)
         OP_LOAD: nxt = d;
         OP_STEP: nxt = cur + W'(1);
         default: nxt = cur;
      endcase
   end

endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
   parameter int W = 4
) (
   input  logic [W-1:0] cur,
   input  logic         en_t,
   output logic         tc
);
   // Terminal-count detect: purely combinational so a chain sees carry at once.
   assign tc = en_t && (&cur);

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr_n,
   input  logic         load_n,
   input  logic         en_p,
   input  logic         en_t,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         tc
);
   logic [W-1:0] q_r;
   logic [W-1:0] q_nxt;

   cnt_next #(.W(W)) u_next (
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (en_t),
      .d      (d),
      .cur    (q_r),
      .nxt    (q_nxt)
   );

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)
         q_r <= '0;
      else
         q_r <= q_nxt;
   end

   cnt_term #(.W(W)) u_term (
      .cur  (q_r),
      .en_t (en_t),
      .tc   (tc)
   );

   assign q = q_r;

endmodule

// File: rtl/casc_cnt_chain.sv
module casc_cnt_chain #(
   parameter int STAGE_W  = 4,
   parameter int N_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          clr_n,
   input  logic                          load_n,
   input  logic [STAGE_W*N_STAGES-1:0]   din,
   input  logic                          cnt_en,
   input  logic                          casc_en,
   output logic [STAGE_W*N_STAGES-1:0]   q,
   output logic                          tc
);
   localparam int TOTAL_W = STAGE_W * N_STAGES;

   if (STAGE_W < 1) begin : g_bad_width
      $error("casc_cnt_chain: STAGE_W must be at least 1");
   end
   if (N_STAGES < 1) begin : g_bad_count
      $error("casc_cnt_chain: N_STAGES must be at least 1");
   end
   if (TOTAL_W > 64) begin : g_too_wide
      $error("casc_cnt_chain: total width above 64 bits");
   end

   if (N_STAGES == 1) begin : g_single
      cnt_stage #(.W(STAGE_W)) u_st (
         .clk    (clk),
         .clr_n  (clr_n),
         .load_n (load_n),
         .en_p   (cnt_en),
         .en_t   (casc_en),
         .d      (din),
         .q      (q),
         .tc     (tc)
      );
   end else begin : g_chain
      logic st_tc [N_STAGES];
      for (genvar k = 0; k < N_STAGES; k++) begin : g_st
         logic en_t_k;
         if (k == 0) begin : g_head
            assign en_t_k = casc_en;
         end else begin : g_link
            assign en_t_k = st_tc[k-1];
         end
         cnt_stage #(.W(STAGE_W)) u_st (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_p   (cnt_en),
            .en_t   (en_t_k),
            .d      (din[k*STAGE_W +: STAGE_W]),
            .q      (q[k*STAGE_W +: STAGE_W]),
            .tc     (st_tc[k])
         );
      end
      assign tc = st_tc[N_STAGES-1];
   end

endmodule

// File: rtl/casc_cnt_chain_chk.sv
module casc_cnt_chain_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         clr_n,
   input logic         load_n,
   input logic [W-1:0] din,
   input logic         cnt_en,
   input logic         casc_en,
   input logic [W-1:0] q,
   input logic         tc
);
   // R1 and R9: clear wins over everything at the edge
   p_clear_zero_r1: assert property (@(posedge clk)
      !clr_n |-> (q == '0));

   p_load_copy_r2: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> (q == $past(din)));

   // R3 and R7: full-width increment across stage boundaries
   p_step_one_r3: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && cnt_en && casc_en) |=> (q == W'($past(q) + W'(1))));

   p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !(cnt_en && casc_en)) |=> $stable(q));

   p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && cnt_en && casc_en && (&q)) |=> (q == '0));

   p_tc_only_max_r6: assert property (@(posedge clk) disable iff (!clr_n)
      tc |-> ((&q) && casc_en));

   p_tc_at_max_r6: assert property (@(posedge clk) disable iff (!clr_n)
      ((&q) && casc_en) |-> tc);

   p_load_max_tc_r8: assert property (@(posedge clk) disable iff (!clr_n)
      (!load_n && (&din)) |=> (tc || !casc_en));

endmodule

bind casc_cnt_chain casc_cnt_chain_chk #(.W(TOTAL_W)) u_chk (.*);

// File: tb/sim_casc_cnt_chain.sv
`timescale 1ns/1ps
module sim_casc_cnt_chain;
   localparam int SW = 4;
   localparam int NS = 2;
   localparam int TW = SW * NS;
   localparam logic [TW-1:0] ONES = '1;

   logic          clk = 1'b0;
   logic          clr_n = 1'b1;
   logic          load_n = 1'b1;
   logic [TW-1:0] din = '0;
   logic          cnt_en = 1'b0;
   logic          casc_en = 1'b0;
   logic [TW-1:0] q;
   logic          tc;

   int n_chk = 0;
   int n_err = 0;
   logic [TW-1:0] exp_q = '0;

   always #5 clk = ~clk;

   casc_cnt_chain #(.STAGE_W(SW), .N_STAGES(NS)) u0 (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
      .cnt_en(cnt_en), .casc_en(casc_en), .q(q), .tc(tc));

   function automatic logic [TW-1:0] f_next(input logic [TW-1:0] cur,
      input logic [TW-1:0] d, input logic ld_n, input logic ep, input logic ec);
      if (!ld_n) return d;
      if (ep && ec) return cur + TW'(1);
      return cur;
   endfunction

   function automatic logic f_tc(input logic [TW-1:0] cur, input logic ec);
      return ec && (cur == ONES);
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // One clock: drive at negedge, check tc before the edge, q and tc after it.
   task automatic cycle(input logic ld_n, input logic ep, input logic ec,
                        input logic [TW-1:0] d, input string req);
      @(negedge clk);
      clr_n = 1'b1; load_n = ld_n; cnt_en = ep; casc_en = ec; din = d;
      #1;
      chk(32'(tc), 32'(f_tc(exp_q, ec)), "R6 tc before edge");
      exp_q = f_next(exp_q, d, ld_n, ep, ec);
      @(posedge clk);
      #1;
      chk(32'(q), 32'(exp_q), req);
      chk(32'(tc), 32'(f_tc(exp_q, ec)), "R6/R8 tc after edge");
   endtask

   task automatic clear_pulse();
      @(negedge clk);
      clr_n = 1'b0; load_n = 1'b0; din = 8'h5A; cnt_en = 1'b1; casc_en = 1'b1;
      #1;
      chk(32'(q), 32'h0, "R1 clear without clock");
      chk(32'(tc), 32'h0, "R1 tc during clear");
      @(posedge clk);
      #1;
      chk(32'(q), 32'h0, "R9 clear beats load at edge");
      exp_q = '0;
   endtask

   function automatic logic [TW-1:0] pick_din();
      case ($urandom % 6)
         0: return ONES;
         1: return ONES - TW'(1);
         2: return TW'(8'h0F);
         3: return TW'(8'h0E);
         4: return TW'(8'h7F);
         default: return TW'($urandom);
      endcase
   endfunction

   initial begin
      void'($urandom(32'h1D5C_0A17));
      #2 clr_n = 1'b0;
      #1 chk(32'(q), 32'h0, "R1 reset state");
      exp_q = '0;

      // Directed corners
      cycle(1'b1, 1'b1, 1'b1, '0, "R3 first step");
      cycle(1'b1, 1'b0, 1'b1, '0, "R4 hold cnt_en low");
      cycle(1'b1, 1'b1, 1'b0, '0, "R4 hold casc_en low");
      cycle(1'b0, 1'b0, 1'b0, TW'(8'hA5), "R2 load with enables low");
      cycle(1'b0, 1'b1, 1'b1, ONES, "R2 R8 load all ones over count");
      cycle(1'b1, 1'b0, 1'b1, '0, "R6 cnt_en low leaves tc high");
      cycle(1'b1, 1'b0, 1'b0, '0, "R6 casc_en low drops tc");
      cycle(1'b1, 1'b1, 1'b1, '0, "R5 wrap to zero");
      cycle(1'b0, 1'b1, 1'b1, TW'(8'h0F), "R2 load stage boundary");
      cycle(1'b1, 1'b1, 1'b1, '0, "R7 carry into upper stage");
      cycle(1'b0, 1'b0, 1'b1, TW'(8'h1F), "R2 load");
      cycle(1'b1, 1'b0, 1'b1, '0, "R7 lower at max upper holds");
      clear_pulse();
      cycle(1'b1, 1'b1, 1'b1, '0, "R3 count after clear");

      // Constrained random
      for (int i = 0; i < 3000; i++) begin
         if ($urandom % 50 == 0) begin
            clear_pulse();
         end else begin
            cycle(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
                  pick_din(), "R3/R4/R7 random");
         end
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #2_000_000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule